// File: doc/BRIEF.md
# Event-Triggered Range Setting Scheduler

This block sets the gain range of a bank of current-amplifier channels in step with the machine cycle. Each channel has a range code for each of sixteen virtual accelerators. A host fills these codes in through a small write port. Writing a code does not change the amplifiers. The amplifiers take new codes only when a chosen machine event arrives and a delay in milliseconds has run out.

The block watches a stream of decoded timing events. When an event carries the trigger number, the block samples the virtual-accelerator index that comes with it. It then counts the programmed delay, using a millisecond tick derived from the system clock. When the delay ends, it loads the output register of every channel with that channel's entry for the sampled index. All channels are loaded on every update, whether or not their code changed. A busy flag is high for the whole wait, so that a self-test sequencer elsewhere can hold off until the update is done.

Top module: `range_sched`

## Requirements
- R1: After reset every output code is 00 (100 nA), `busy` and `upd_stb` are low, every table entry holds 00, and the trigger number register holds RST_EVT (55).
- R2: Range codes are 00 = 100 nA, 10 = 1 uA and 11 = 10 uA. A table write that carries code 01 is ignored and the entry keeps its old value, so 01 never reaches an output.
- R3: `tbl_we` stores `tbl_code` in the entry selected by channel `tbl_ch` and index `tbl_vacc`. A write to a channel address of N_CH or above is ignored. Table writes never change `rng_out` directly.
- R4: An update starts only in a cycle where `evt_valid` is high and `evt_num` equals the trigger register. Writing `reg_wdata` with `reg_addr`=0 sets the 16-bit trigger register. Any other event is ignored.
- R5: Writing with `reg_addr`=1 sets the 16-bit delay D in milliseconds (reset 0). The outputs take their new values exactly max(D,1)×TICK_DIV clock cycles after the edge that sampled the matching event. D=0 and D=1 both wait one tick.
- R6: The `evt_vacc` index sampled with the matching event selects the entry. On update, every channel c gets its own entry for that index on `rng_out[2c+1:2c]`.
- R7: `busy` is high from the cycle after a matching event until the cycle in which the new outputs appear, and low at all other times.
- R8: A matching event that arrives while an update is pending restarts the delay and samples the index again. The earlier pending update is dropped.
- R9: `upd_stb` is a single-cycle pulse, high exactly in the first cycle in which the updated `rng_out` values are visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_ch | input | CH_W | Channel address of the table write |
| tbl_vacc | input | 4 | Virtual-accelerator index of the table write |
| tbl_code | input | 2 | Range code to store |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 1 | 0 = trigger event number, 1 = delay in ms |
| reg_wdata | input | DATA_W | Control register write data |
| evt_valid | input | 1 | Decoded timing event present |
| evt_num | input | DATA_W | Event number of the timing event |
| evt_vacc | input | 4 | Virtual-accelerator index carried with the event |
| rng_out | output | 2*N_CH | Applied range code per channel, channel c in bits [2c+1:2c] |
| busy | output | 1 | Range update pending |
| upd_stb | output | 1 | One-cycle pulse when new ranges appear |

## Verification
The bench builds the block with N_CH=3 and TICK_DIV=4. With three channels the unused channel address 3 exists, so the rule that out-of-range writes are ignored can be checked. With a prescaler of four, a delay of several milliseconds lasts only a few dozen cycles, so the bench can check the exact update cycle many times over: for D=0 and D=1, for random delays, for a restart partway through a delay, and for a re-programmed trigger number. Random table writes that include the illegal code and the unused channel check that the applied values follow the staged table.

// File: rtl/range_sched_pkg.sv
package range_sched_pkg;

  localparam int RANGE_W = 2;
  localparam int VACC_W  = 4;
  localparam int N_VACC  = 1 << VACC_W;

  typedef logic [RANGE_W-1:0] range_t;

  localparam range_t RNG_100NA = 2'b00;
  localparam range_t RNG_1UA   = 2'b10;
  localparam range_t RNG_10UA  = 2'b11;

  // control register select
  localparam logic REG_TRIG_EVT = 1'b0;
  localparam logic REG_DELAY_MS = 1'b1;

  // a code is usable unless it is the undefined pattern 01
  function automatic logic range_legal(input range_t code);
    return code != 2'b01;
  endfunction

  // true when the tick being counted is the final one of the delay
  function automatic logic last_tick(input logic [31:0] remaining);
    return remaining <= 32'd1;
  endfunction

  // number of millisecond ticks from event to update
  function automatic logic [31:0] ticks_for_delay(input logic [31:0] delay_ms);
    return (delay_ms == 32'd0) ? 32'd1 : delay_ms;
  endfunction

endpackage

// File: rtl/rs_cfg_regs.sv
module rs_cfg_regs #(
  parameter int DATA_W  = 16,
  parameter int RST_EVT = 55,
  parameter int RST_DLY = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] trig_evt,
  output logic [DATA_W-1:0] delay_ms
);
  import range_sched_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_evt <= DATA_W'(RST_EVT);
      delay_ms <= DATA_W'(RST_DLY);
    end else if (reg_we) begin
      if (reg_addr == REG_TRIG_EVT) trig_evt <= reg_wdata;
      else                          delay_ms <= reg_wdata;
    end
  end

endmodule

// File: rtl/rs_range_table.sv
module rs_range_table #(
  parameter int N_CH = 8,
  parameter int CH_W = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_en,
  input  logic [CH_W-1:0]                         wr_ch,
  input  logic [range_sched_pkg::VACC_W-1:0]      wr_vacc,
  input  logic [range_sched_pkg::RANGE_W-1:0]     wr_code,
  input  logic [range_sched_pkg::VACC_W-1:0]      rd_vacc,
  output logic [N_CH*range_sched_pkg::RANGE_W-1:0] rd_codes
);
  import range_sched_pkg::*;

  logic wr_ok;
  assign wr_ok = wr_en && range_legal(wr_code);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    range_t entry [N_VACC];
    logic   sel;

    assign sel = wr_ok && (wr_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int v = 0; v < N_VACC; v++) entry[v] <= RNG_100NA;
      end else if (sel) begin
        entry[wr_vacc] <= wr_code;
      end
    end

    assign rd_codes[c*RANGE_W +: RANGE_W] = entry[rd_vacc];
  end

endmodule

// File: rtl/rs_delay_timer.sv
module rs_delay_timer #(
  parameter int TICK_DIV = 1000,
  parameter int DLY_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] delay_ms,
  output logic             pending,
  output logic             ms_tick,
  output logic             fire
);
  import range_sched_pkg::*;

  localparam int PC_W = $clog2(TICK_DIV + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(TICK_DIV - 1);

  logic [PC_W-1:0]  pcnt;
  logic [DLY_W-1:0] remaining;
  logic             at_last;

  assign ms_tick = pending && (pcnt == PC_LAST);
  assign at_last = last_tick(32'(remaining));
  // a restart in the same cycle overrides the pending completion
  assign fire    = ms_tick && at_last && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      remaining <= '0;
      pcnt      <= '0;
    end else if (start) begin
      pending   <= 1'b1;
      remaining <= delay_ms;
      pcnt      <= '0;
    end else if (pending) begin
      if (ms_tick) begin
        pcnt <= '0;
        if (at_last) pending   <= 1'b0;
        else         remaining <= remaining - DLY_W'(1);
      end else begin
        pcnt <= pcnt + PC_W'(1);
      end
    end
  end

endmodule

// File: rtl/range_sched.sv
module range_sched #(
  parameter int N_CH     = 8,
  parameter int TICK_DIV = 1000,
  parameter int DATA_W   = 16,
  parameter int RST_EVT  = 55,
  parameter int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_we,
  input  logic [CH_W-1:0]        tbl_ch,
  input  logic [3:0]             tbl_vacc,
  input  logic [1:0]             tbl_code,
  input  logic                   reg_we,
  input  logic                   reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  input  logic                   evt_valid,
  input  logic [DATA_W-1:0]      evt_num,
  input  logic [3:0]             evt_vacc,
  output logic [2*N_CH-1:0]      rng_out,
  output logic                   busy,
  output logic                   upd_stb
);
  import range_sched_pkg::*;

  localparam int OUT_W = N_CH * RANGE_W;

  logic [DATA_W-1:0] trig_evt;
  logic [DATA_W-1:0] delay_ms;
  logic [VACC_W-1:0] vacc_q;
  logic [OUT_W-1:0]  staged;
  logic              evt_hit;
  logic              pending;
  logic              ms_tick;
  logic              fire;

  rs_cfg_regs #(
    .DATA_W (DATA_W),
    .RST_EVT(RST_EVT),
    .RST_DLY(0)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .trig_evt (trig_evt),
    .delay_ms (delay_ms)
  );

  rs_range_table #(
    .N_CH(N_CH),
    .CH_W(CH_W)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_ch   (tbl_ch),
    .wr_vacc (tbl_vacc),
    .wr_code (tbl_code),
    .rd_vacc (vacc_q),
    .rd_codes(staged)
  );

  assign evt_hit = evt_valid && (evt_num == trig_evt);

  // index travels with the event and is held for the whole delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vacc_q <= '0;
    else if (evt_hit) vacc_q <= evt_vacc;
  end

  rs_delay_timer #(
    .TICK_DIV(TICK_DIV),
    .DLY_W   (DATA_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (evt_hit),
    .delay_ms(delay_ms),
    .pending (pending),
    .ms_tick (ms_tick),
    .fire    (fire)
  );

  // output register: every channel reloaded on each update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_out <= '0;
      upd_stb <= 1'b0;
    end else begin
      upd_stb <= fire;
      if (fire) rng_out <= staged;
    end
  end

  assign busy = pending;

endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int N_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*N_CH-1:0] rng_out,
  input logic              busy,
  input logic              upd_stb,
  input logic              evt_hit,
  input logic              ms_tick,
  input logic              fire
);

  AST_BUSY_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> busy) else $error("busy not raised after event match"); // R7

  AST_BUSY_FALL_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> upd_stb) else $error("busy dropped without update"); // R7

  AST_UPD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> !busy) else $error("update pulse while still busy"); // R9

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb) else $error("update pulse longer than one cycle"); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> (rng_out == $past(rng_out))) else $error("outputs moved outside update"); // R3

  AST_NO_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ms_tick) else $error("ms tick counted while idle"); // R5

  AST_FIRE_TO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> upd_stb) else $error("fire not followed by update pulse"); // R9

  for (genvar c = 0; c < N_CH; c++) begin : g_leg
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rng_out[2*c +: 2] != 2'b01) else $error("illegal code on output"); // R2
  end

endmodule

bind range_sched rs_sched_chk #(.N_CH(N_CH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rng_out(rng_out),
  .busy   (busy),
  .upd_stb(upd_stb),
  .evt_hit(evt_hit),
  .ms_tick(ms_tick),
  .fire   (fire)
);

// File: tb/range_sched_bench.sv
module range_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 3;
  localparam int TDIV = 4;
  localparam int CHW  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tbl_we = 1'b0;
  logic [CHW-1:0]    tbl_ch = '0;
  logic [3:0]        tbl_vacc = '0;
  logic [1:0]        tbl_code = '0;
  logic              reg_we = 1'b0;
  logic              reg_addr = 1'b0;
  logic [15:0]       reg_wdata = '0;
  logic              evt_valid = 1'b0;
  logic [15:0]       evt_num = '0;
  logic [3:0]        evt_vacc = '0;
  logic [2*NCH-1:0]  rng_out;
  logic              busy;
  logic              upd_stb;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0]  m_tbl [NCH][16];
  logic [15:0] m_trig = 16'd55;
  int          m_dly = 0;
  logic [2*NCH-1:0] m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_sched #(.N_CH(NCH), .TICK_DIV(TDIV), .DATA_W(16), .RST_EVT(55)) u_range_sched (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_ch(tbl_ch), .tbl_vacc(tbl_vacc),
    .tbl_code(tbl_code), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .evt_valid(evt_valid), .evt_num(evt_num), .evt_vacc(evt_vacc),
    .rng_out(rng_out), .busy(busy), .upd_stb(upd_stb)
  );

  function automatic int wait_len(input int d);
    int n;
    n = d;
    if (n < 1) n = 1;
    return n * TDIV;
  endfunction

  function automatic logic [2*NCH-1:0] model_out(input logic [3:0] v);
    logic [2*NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[2*c +: 2] = m_tbl[c][v];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tbl_write(input int ch, input int v, input logic [1:0] code);
    @(negedge clk);
    tbl_we = 1'b1; tbl_ch = CHW'(ch); tbl_vacc = 4'(v); tbl_code = code;
    @(negedge clk);
    tbl_we = 1'b0;
    if (ch < NCH && code != 2'b01) m_tbl[ch][v] = code;
  endtask

  task automatic reg_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a) m_dly = int'(d); else m_trig = d;
  endtask

  // drives one event; returns after the sampling edge, at the next negedge
  task automatic send_event(input logic [15:0] num, input logic [3:0] v, input logic valid);
    @(negedge clk);
    evt_valid = valid; evt_num = num; evt_vacc = v;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic run_update(input logic [3:0] v, input string tag);
    int t;
    logic [2*NCH-1:0] nxt;
    t = wait_len(m_dly);
    nxt = model_out(v);
    send_event(m_trig, v, 1'b1);
    chk({tag, " R7 busy after match"}, 32'(busy), 32'd1);
    repeat (t - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " R5 outputs held before delay end"}, 32'(rng_out), 32'(m_out));
    chk({tag, " R7 busy during delay"}, 32'(busy), 32'd1);
    @(negedge clk);
    m_out = nxt;
    chk({tag, " R6 outputs after update"}, 32'(rng_out), 32'(m_out));
    chk({tag, " R9 update pulse"}, 32'(upd_stb), 32'd1);
    chk({tag, " R7 busy clear"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk({tag, " R9 pulse single cycle"}, 32'(upd_stb), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r_ch, r_v, r_d;
    logic [1:0] r_code;
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) for (int v = 0; v < 16; v++) m_tbl[c][v] = 2'b00;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", 32'(rng_out), 32'd0);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset strobe", 32'(upd_stb), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 unwritten entries give 100 nA, trigger 55 at reset
    tbl_write(0, 3, 2'b11);
    chk("R3 write leaves outputs", 32'(rng_out), 32'd0);
    run_update(4'd9, "R1 default entries");
    run_update(4'd3, "R4 reset trigger 55");

    // R2 illegal code ignored, legal codes applied
    tbl_write(1, 5, 2'b10);
    tbl_write(2, 5, 2'b11);
    tbl_write(1, 5, 2'b01);
    chk("R2 model keeps 10", 32'(m_tbl[1][5]), 32'd2);
    run_update(4'd5, "R2 codes");
    // R3 channel address 3 ignored
    tbl_write(3, 5, 2'b10);
    run_update(4'd5, "R3 unused channel");

    // R5 delay 0 and 1 equal, longer delay exact
    reg_write(1'b1, 16'd1);
    run_update(4'd3, "R5 delay one");
    reg_write(1'b1, 16'd5);
    run_update(4'd5, "R5 delay five");

    // R4 non-matching and invalid events ignored
    send_event(16'd56, 4'd0, 1'b1);
    chk("R4 wrong number no busy", 32'(busy), 32'd0);
    send_event(m_trig, 4'd0, 1'b0);
    chk("R4 invalid event no busy", 32'(busy), 32'd0);
    repeat (8 * TDIV) @(negedge clk);
    chk("R4 outputs unchanged", 32'(rng_out), 32'(m_out));

    // R4 new trigger number
    reg_write(1'b0, 16'h1234);
    send_event(16'd55, 4'd0, 1'b1);
    chk("R4 old number ignored", 32'(busy), 32'd0);
    reg_write(1'b1, 16'd0);
    run_update(4'd0, "R4 new trigger");

    // R8 restart during a pending delay with another index
    reg_write(1'b1, 16'd3);
    tbl_write(0, 12, 2'b10);
    send_event(m_trig, 4'd5, 1'b1);
    repeat (2 * TDIV) @(negedge clk);
    chk("R8 still pending", 32'(busy), 32'd1);
    run_update(4'd12, "R8 restart");

    // random mix
    for (int it = 0; it < 14; it++) begin
      for (int k = 0; k < 6; k++) begin
        r_ch = int'($urandom_range(0, 3));
        r_v = int'($urandom_range(0, 15));
        r_code = 2'($urandom_range(0, 3));
        tbl_write(r_ch, r_v, r_code);
      end
      chk("R3 random writes hold outputs", 32'(rng_out), 32'(m_out));
      r_d = int'($urandom_range(0, 3));
      reg_write(1'b1, 16'(r_d));
      run_update(4'($urandom_range(0, 15)), "R6 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule